// File: doc/BRIEF.md
# Priority-Resolved Pin Function Multiplexer

This block chooses, for each pin of a small multi-function pin bank, which one of several on-chip signals drives it. Each pin offers up to five priority levels. Level 0 has the highest priority and the last level is a fixed fallback signal. A level becomes active when any of its expressions is true. An expression is true when all of its compare terms hold. A term picks a source word, applies a bit mask, shifts the masked field down to bit 0 and compares it with a constant. The highest active level wins. The fallback applies only when no higher level is active.

The source words are four writable 32-bit control registers and one read-only strap word. The strap word is captured from an input while reset is held. A simple single-cycle port writes and reads these words. The block outputs, for every pin, a one-hot select over its levels and the index of the winning level. Both outputs are combinational from the stored words.

The pin table is fixed in the package. Pin 0 has a single level-0 signal. Pin 1 has level-0 and level-1 signals driven from different registers. Pin 2's level 0 is enabled by either a control bit or a strap bit. Pin 3 needs a three-register AND. Pin 4 uses a 2-bit video mode field. Pin 5 has a level 1 that is enabled by a strap bit being low. Pin 6 uses levels 0, 2 and 4 only.

Top module: `pin_func_mux`

## Requirements
- R1: While reset is held, all four control registers clear to zero. At the first cycle after reset, every pin whose table does not involve the strap word selects its fallback level 4.
- R2: A write with `wr_en_i` high and `addr_i` in 0..3 updates that control register at the next rising edge. Reading addresses 0..3 returns the control registers. Writes to addresses 4..7 change no control register and no strap bit. Reads of 5..7 return zero.
- R3: The strap word is loaded from `strap_i` on every clock edge while reset is held and is constant afterwards. Address 4 reads it back. A strap-enabled level cannot be turned off through the register port.
- R4: A term is true when (word AND mask), shifted right by the index of the lowest mask bit, equals the term's value. Bits of the word outside the mask have no effect.
- R5: An expression is true only when all of its terms are true.
- R6: A level is active when any of its expressions is true. Pin 2 level 0 = reg0[12]==1 OR strap[14]==1. Pin 5 level 1 = reg1[12]==1 OR strap[19]==0. Pin 5 level 0 = reg0[25]==1.
- R7: Each pin selects exactly one level: the lowest-numbered active level. `pin_sel_o[p*5+l]` is the select bit for pin p, level l. `pin_lvl_o[p*3 +: 3]` carries the winning level's index. Pin 0 level 0 = reg0[0]==1. Pin 1 level 0 = reg2[22]==1 and pin 1 level 1 = reg0[4]==1.
- R8: When no level 0..3 is active on a pin, that pin selects level 4.
- R9: Pin 4 level 0 is active when reg2[5:4] is 1, 2 or 3 and reg3[17]==1. Pin 4 level 1 is active when reg3[17]==1.
- R10: Pin 3 level 0 needs reg1[3]==1, reg0[15]==1 and reg2[31]==0. Pin 3 level 1 needs the same first two bits with reg2[31]==1.
- R11: Pin 6 level 0 = reg3[0]==1 and pin 6 level 2 = reg3[2:1]==1. Levels 1 and 3 of pin 6 are never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap capture window |
| strap_i | input | 32 | Strap value captured during reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word address (0..3 control, 4 strap) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| pin_sel_o | output | 35 | One-hot level select, 5 bits per pin |
| pin_lvl_o | output | 21 | Winning level index, 3 bits per pin |

## Verification
Two resolution paths can meet on one pin in the same cycle: an OR path raising a level, and a higher level taking over from it. For pin 1, the bench first makes level 1 active and then also sets the level-0 bit, so both levels are true together. Only level 0 may then show, and clearing the level-0 bit must hand the pin back to level 1 without a gap. The same happens between the strap path and the register path. After a reset with strap[14] high, a register write that clears reg0[12] must leave pin 2 on level 0. The bench judges each case by sampling the select and index outputs one half cycle after the write edge.

// File: rtl/pmx_pkg.sv
`timescale 1ns/1ps
package pmx_pkg;

    localparam int PMX_DW        = 32;
    localparam int PMX_CTRL_REGS = 4;
    localparam int PMX_STRAP_IDX = PMX_CTRL_REGS;
    localparam int PMX_WORDS     = PMX_CTRL_REGS + 1;
    localparam int PMX_SRC_W     = $clog2(PMX_WORDS);
    localparam int PMX_PINS      = 7;
    localparam int PMX_LEVELS    = 5;
    localparam int PMX_LVL_W     = $clog2(PMX_LEVELS);
    localparam int PMX_EXPRS     = 3;
    localparam int PMX_TERMS     = 3;

    typedef struct packed {
        logic                 used;
        logic [PMX_SRC_W-1:0] src;
        logic [PMX_DW-1:0]    mask;
        logic [PMX_DW-1:0]    match;
    } pmx_term_t;

    // Build a term over word[src][hi:lo] compared with val
    function automatic pmx_term_t pmx_mk(int src, int hi, int lo, int val);
        pmx_term_t d;
        d.used  = 1'b1;
        d.src   = PMX_SRC_W'(src);
        d.mask  = ((PMX_DW'(1) << (hi - lo + 1)) - PMX_DW'(1)) << lo;
        d.match = PMX_DW'(val);
        return d;
    endfunction

    function automatic int pmx_lsb(logic [PMX_DW-1:0] m);
        int   r;
        logic found;
        r     = 0;
        found = 1'b0;
        for (int i = 0; i < PMX_DW; i++) begin
            if (!found && m[i]) begin
                r     = i;
                found = 1'b1;
            end
        end
        return r;
    endfunction

    // Pin table: term t of expression e of level l on pin p
    function automatic pmx_term_t pmx_term_of(int p, int l, int e, int t);
        pmx_term_t d;
        d = '0;
        case (p)
            0: if (l == 0 && e == 0 && t == 0) d = pmx_mk(0, 0, 0, 1);
            1: begin
                if (l == 0 && e == 0 && t == 0)      d = pmx_mk(2, 22, 22, 1);
                else if (l == 1 && e == 0 && t == 0) d = pmx_mk(0, 4, 4, 1);
            end
            2: if (l == 0 && t == 0) begin
                if (e == 0)      d = pmx_mk(0, 12, 12, 1);
                else if (e == 1) d = pmx_mk(PMX_STRAP_IDX, 14, 14, 1);
            end
            3: if (e == 0 && (l == 0 || l == 1)) begin
                if (t == 0)      d = pmx_mk(1, 3, 3, 1);
                else if (t == 1) d = pmx_mk(0, 15, 15, 1);
                else if (t == 2) d = pmx_mk(2, 31, 31, (l == 1) ? 1 : 0);
            end
            4: begin
                if (l == 0 && e < 3) begin
                    if (t == 0)      d = pmx_mk(2, 5, 4, e + 1);
                    else if (t == 1) d = pmx_mk(3, 17, 17, 1);
                end else if (l == 1 && e == 0 && t == 0) begin
                    d = pmx_mk(3, 17, 17, 1);
                end
            end
            5: begin
                if (l == 0 && e == 0 && t == 0) d = pmx_mk(0, 25, 25, 1);
                else if (l == 1 && t == 0) begin
                    if (e == 0)      d = pmx_mk(1, 12, 12, 1);
                    else if (e == 1) d = pmx_mk(PMX_STRAP_IDX, 19, 19, 0);
                end
            end
            6: begin
                if (l == 0 && e == 0 && t == 0)      d = pmx_mk(3, 0, 0, 1);
                else if (l == 2 && e == 0 && t == 0) d = pmx_mk(3, 2, 1, 1);
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pmx_regfile.sv
`timescale 1ns/1ps
module pmx_regfile #(
    parameter int DW    = 32,
    parameter int NCTRL = 4,
    parameter int AW    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DW-1:0]             strap_i,
    input  logic                      wr_en_i,
    input  logic [AW-1:0]             addr_i,
    input  logic [DW-1:0]             wdata_i,
    output logic [NCTRL-1:0][DW-1:0]  ctrl_o,
    output logic [DW-1:0]             strap_o,
    output logic [DW-1:0]             rdata_o
);
    localparam int IDX_W = (NCTRL > 1) ? $clog2(NCTRL) : 1;

    typedef struct packed {
        logic [NCTRL-1:0][DW-1:0] ctrl;
        logic [DW-1:0]            strap;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic      ctrl_hit;

    assign ctrl_hit = (addr_i < AW'(NCTRL));

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.ctrl  = '0;
            st_d.strap = strap_i;
        end else if (wr_en_i && ctrl_hit) begin
            st_d.ctrl[addr_i[IDX_W-1:0]] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        if (ctrl_hit)                   rdata_o = st_q.ctrl[addr_i[IDX_W-1:0]];
        else if (addr_i == AW'(NCTRL))  rdata_o = st_q.strap;
        else                            rdata_o = '0;
    end

    assign ctrl_o  = st_q.ctrl;
    assign strap_o = st_q.strap;
endmodule

// File: rtl/pmx_term.sv
`timescale 1ns/1ps
module pmx_term #(
    parameter int            DW    = 32,
    parameter logic [DW-1:0] MASK  = '1,
    parameter logic [DW-1:0] MATCH = '0
) (
    input  logic [DW-1:0] word_i,
    output logic          hit_o
);
    localparam int SHIFT = pmx_pkg::pmx_lsb(MASK);

    logic [DW-1:0] field;

    assign field = (word_i & MASK) >> SHIFT;
    assign hit_o = (field == MATCH);
endmodule

// File: rtl/pmx_prio.sv
`timescale 1ns/1ps
module pmx_prio #(
    parameter int NL = 5,
    parameter int LW = 3
) (
    input  logic [NL-2:0] act_i,
    output logic [NL-1:0] sel_o,
    output logic [LW-1:0] lvl_o
);
    always_comb begin
        lvl_o = LW'(NL - 1);
        for (int l = NL - 2; l >= 0; l--) begin
            if (act_i[l]) lvl_o = LW'(l);
        end
        sel_o        = '0;
        sel_o[lvl_o] = 1'b1;
    end
endmodule

// File: rtl/pin_func_mux.sv
`timescale 1ns/1ps
module pin_func_mux
    import pmx_pkg::*;
#(
    parameter int DATA_W = PMX_DW,
    parameter int ADDR_W = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [DATA_W-1:0]               strap_i,
    input  logic                            wr_en_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [DATA_W-1:0]               wdata_i,
    output logic [DATA_W-1:0]               rdata_o,
    output logic [PMX_PINS*PMX_LEVELS-1:0]  pin_sel_o,
    output logic [PMX_PINS*PMX_LVL_W-1:0]   pin_lvl_o
);
    logic [PMX_CTRL_REGS-1:0][DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0]                    strap_q;
    logic [DATA_W-1:0]                    words [PMX_WORDS];

    pmx_regfile #(
        .DW    (DATA_W),
        .NCTRL (PMX_CTRL_REGS),
        .AW    (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (strap_i),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .ctrl_o  (ctrl_q),
        .strap_o (strap_q),
        .rdata_o (rdata_o)
    );

    for (genvar w = 0; w < PMX_CTRL_REGS; w++) begin : g_word
        assign words[w] = ctrl_q[w];
    end
    assign words[PMX_STRAP_IDX] = strap_q;

    for (genvar p = 0; p < PMX_PINS; p++) begin : g_pin
        logic [PMX_LEVELS-2:0] act;

        for (genvar l = 0; l < PMX_LEVELS - 1; l++) begin : g_lvl
            logic [PMX_EXPRS-1:0] eh;

            for (genvar e = 0; e < PMX_EXPRS; e++) begin : g_expr
                localparam bit PRESENT = pmx_term_of(p, l, e, 0).used;
                logic [PMX_TERMS-1:0] th;

                for (genvar t = 0; t < PMX_TERMS; t++) begin : g_term
                    localparam pmx_term_t TD = pmx_term_of(p, l, e, t);
                    if (TD.used) begin : g_on
                        pmx_term #(
                            .DW    (DATA_W),
                            .MASK  (TD.mask),
                            .MATCH (TD.match)
                        ) u_term (
                            .word_i (words[TD.src]),
                            .hit_o  (th[t])
                        );
                    end else begin : g_off
                        assign th[t] = 1'b1;
                    end
                end

                assign eh[e] = PRESENT && (&th);
            end

            assign act[l] = |eh;
        end

        pmx_prio #(
            .NL (PMX_LEVELS),
            .LW (PMX_LVL_W)
        ) u_prio (
            .act_i (act),
            .sel_o (pin_sel_o[p*PMX_LEVELS +: PMX_LEVELS]),
            .lvl_o (pin_lvl_o[p*PMX_LVL_W +: PMX_LVL_W])
        );
    end
endmodule

// File: rtl/pmx_chk.sv
`timescale 1ns/1ps
module pmx_chk
    import pmx_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en_i,
    input logic [AW-1:0]                   addr_i,
    input logic [DW-1:0]                   wdata_i,
    input logic [PMX_CTRL_REGS-1:0][DW-1:0] ctrl_q,
    input logic [DW-1:0]                   strap_q,
    input logic [PMX_PINS*PMX_LEVELS-1:0]  pin_sel_o
);
    localparam int IDX_W = $clog2(PMX_CTRL_REGS);

    // R2
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i < AW'(PMX_CTRL_REGS))
        |=> ctrl_q[$past(addr_i[IDX_W-1:0])] == $past(wdata_i));

    // R2
    wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i >= AW'(PMX_CTRL_REGS)) |=> $stable(ctrl_q));

    // R3
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));

    // R6
    strap_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strap_q[14] |-> pin_sel_o[2*PMX_LEVELS]);

    for (genvar p = 0; p < PMX_PINS; p++) begin : g_pin
        // R7
        one_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(pin_sel_o[p*PMX_LEVELS +: PMX_LEVELS]) == 1);

        for (genvar l = 0; l < PMX_LEVELS - 1; l++) begin : g_lvl
            if (!pmx_term_of(p, l, 0, 0).used) begin : g_empty
                // R11
                empty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    !pin_sel_o[p*PMX_LEVELS + l]);
            end
        end
    end
endmodule

bind pin_func_mux pmx_chk #(
    .DW (DATA_W),
    .AW (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .ctrl_q    (ctrl_q),
    .strap_q   (strap_q),
    .pin_sel_o (pin_sel_o)
);

// File: tb/pin_func_mux_tb.sv
`timescale 1ns/1ps
module pin_func_mux_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] strap_i;
    logic        wr_en_i;
    logic [2:0]  addr_i;
    logic [31:0] wdata_i;
    logic [31:0] rdata_o;
    logic [34:0] pin_sel_o;
    logic [20:0] pin_lvl_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pin_func_mux dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_i   (strap_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .pin_sel_o (pin_sel_o),
        .pin_lvl_o (pin_lvl_o)
    );

    task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_pin(string req, int p, int lvl);
        logic [4:0] s;
        logic [2:0] v;
        s = pin_sel_o[p*5 +: 5];
        v = pin_lvl_o[p*3 +: 3];
        n_chk++;
        if (s !== 5'(1 << lvl) || v !== 3'(lvl)) begin
            n_fail++;
            $display("FAIL %s pin %0d: actual sel %b lvl %0d expected sel %b lvl %0d",
                     req, p, s, v, 5'(1 << lvl), lvl);
        end
    endtask

    task automatic do_reset(logic [31:0] strap);
        @(negedge clk);
        rst_n   = 1'b0;
        strap_i = strap;
        wr_en_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1;
        addr_i  = a;
        wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic clear_ctrl();
        for (int i = 0; i < 4; i++) wr(3'(i), 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset(32'h00A8_0000);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            rd(3'(i), d);
            check_eq("R1", "ctrl after reset", d, 32'h0);
        end
        for (int p = 0; p < 7; p++) check_pin("R1", p, 4);
        rd(3'd4, d);
        check_eq("R3", "strap readback", d, 32'h00A8_0000);
        strap_i = 32'h0000_4000;
        repeat (3) @(negedge clk);
        rd(3'd4, d);
        check_eq("R3", "strap held after reset", d, 32'h00A8_0000);
        check_pin("R3", 2, 4);
        check_pin("R3", 5, 4);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(3'd1, 32'hDEAD_BEEF);
        rd(3'd1, d);
        check_eq("R2", "reg1 write", d, 32'hDEAD_BEEF);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d);
        check_eq("R2", "strap write ignored", d, 32'h00A8_0000);
        check_pin("R2", 2, 4);
        wr(3'd6, 32'h1234_5678);
        rd(3'd6, d);
        check_eq("R2", "unmapped read", d, 32'h0);
        rd(3'd0, d);
        check_eq("R2", "reg0 untouched", d, 32'h0);
        rd(3'd1, d);
        check_eq("R2", "reg1 untouched", d, 32'hDEAD_BEEF);
        clear_ctrl();
    endtask

    task automatic t_single_dual();
        wr(3'd0, 32'h0000_0001);
        check_pin("R7", 0, 0);
        check_pin("R8", 1, 4);
        wr(3'd0, 32'h0000_0010);
        check_pin("R8", 0, 4);
        check_pin("R7", 1, 1);
        wr(3'd2, 32'h0040_0000);
        check_pin("R7", 1, 0);
        wr(3'd2, 32'h0);
        check_pin("R7", 1, 1);
        clear_ctrl();
        check_pin("R8", 1, 4);
    endtask

    task automatic t_or_regs();
        wr(3'd0, 32'h0000_1000);
        check_pin("R6", 2, 0);
        wr(3'd1, 32'h0000_1000);
        check_pin("R6", 5, 1);
        wr(3'd0, 32'h0200_1000);
        check_pin("R6", 5, 0);
        clear_ctrl();
        check_pin("R6", 2, 4);
        check_pin("R6", 5, 4);
    endtask

    task automatic t_and();
        wr(3'd1, 32'h0000_0008);
        check_pin("R5", 3, 4);
        wr(3'd0, 32'h0000_8000);
        check_pin("R10", 3, 0);
        wr(3'd2, 32'h8000_0000);
        check_pin("R10", 3, 1);
        wr(3'd1, 32'h0);
        check_pin("R5", 3, 4);
        clear_ctrl();
    endtask

    task automatic t_video();
        wr(3'd3, 32'h0002_0000);
        check_pin("R9", 4, 1);
        for (int m = 1; m < 4; m++) begin
            wr(3'd2, 32'(m) << 4);
            check_pin("R9", 4, 0);
        end
        wr(3'd2, 32'h0000_00C0);
        check_pin("R4", 4, 1);
        wr(3'd2, 32'h0000_0030);
        wr(3'd3, 32'h0);
        check_pin("R9", 4, 4);
        clear_ctrl();
    endtask

    task automatic t_five();
        wr(3'd3, 32'h0000_0001);
        check_pin("R11", 6, 0);
        wr(3'd3, 32'h0000_0002);
        check_pin("R11", 6, 2);
        wr(3'd3, 32'h0000_0004);
        check_pin("R4", 6, 4);
        wr(3'd3, 32'h0000_0003);
        check_pin("R11", 6, 0);
        clear_ctrl();
    endtask

    task automatic t_strap();
        do_reset(32'h0000_4000);
        @(negedge clk);
        check_pin("R3", 2, 0);
        check_pin("R6", 5, 1);
        wr(3'd0, 32'h0);
        check_pin("R3", 2, 0);
        wr(3'd0, 32'h0200_0000);
        check_pin("R7", 5, 0);
        clear_ctrl();
    endtask

    initial begin
        rst_n   = 1'b0;
        strap_i = 32'h0;
        wr_en_i = 1'b0;
        addr_i  = 3'd0;
        wdata_i = 32'h0;
        t_reset();
        t_regs();
        t_single_dual();
        t_or_regs();
        t_and();
        t_video();
        t_five();
        t_strap();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule